// File: doc/BRIEF.md
# Three-State Snooping Coherent Cache Subsystem

This block joins several requester ports to one shared word memory. Each port has a private direct-mapped cache. Every cache line is in one of three states:

- **Invalid**: the line holds no usable data.
- **Shared**: the line may be read, and other caches may hold identical copies.
- **Owned**: this is the only cached copy, and it may be read and written.

Accesses that a cache can serve alone complete locally in one cycle. Every other access becomes a transaction on one internal bus, and a round-robin arbiter grants that bus to one transaction at a time. A granted transaction runs three fixed phases:

1. **Victim write-back slot**: the requester's own owned victim, if any, is written to memory.
2. **Snoop**: the other caches invalidate or downgrade their copies, and an owner writes its word back.
3. **Memory read and fill**: the requester's line is filled from memory.

Because every miss and every upgrade passes through this single serialized bus, all ports observe one order of writes to each address.

Each port has a valid/ready request channel. A request carries a write flag, a word address and write data. The requester must hold valid and all fields stable until ready is seen high at a clock edge. Ready is low while the port waits for its own bus transaction. Ready is also low during any cycle in which the bus is snooping that port's cache. Each port holds at most one request at a time.

Responses are single-cycle done pulses and cannot be back-pressured. The data beside a pulse is the loaded word for a load, and an echo of the written word for a store.

Top module: `coh_snoop_top`

## Requirements
- R1: After reset every cache line is Invalid, every `req_ready` is high, every `rsp_valid` is low, and every memory word reads as zero.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Each accepted request yields exactly one single-cycle `rsp_valid` pulse. `rsp_rdata` carries the loaded word for a load, and the written word for a store.
- R3: Two kinds of access are hits: a load whose line (index = low 3 address bits) is Shared or Owned with a matching tag (high 3 address bits), and a store whose line is Owned with a matching tag. A hit raises `rsp_valid` at the acceptance edge itself and uses no bus cycle.
- R4: Every non-hit access goes to the bus. With the bus idle, its `rsp_valid` rises exactly four edges after the acceptance edge.
- R5: A load miss downgrades any current owner. The owner writes its word back and keeps the line as Shared: its next load hits, and its next store goes to the bus. The requesting line becomes Shared.
- R6: A store to an Invalid or Shared line invalidates all other copies, with no write-back from sharers. The requester's line becomes Owned and holds the written word. Any other port's next load of that address is a miss.
- R7: Every load returns the word of the most recent store to that address, ordered by response pulse, or zero if no store has been made since reset.
- R8: When a bus access needs a line whose index is held Owned under another tag, the owned word is written back before the refill, so later loads of the evicted address see it.
- R9: The arbiter serves requesting ports in round-robin order. The pointer starts at port 0 after reset, and after each grant the port above the granted one has priority. Ports missing together right after reset finish in ascending port order, four cycles apart.
- R10: At most one cache owns an address, at most one cache writes back during a snoop, and a fill goes only to a port with a pending bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | Per-port request valid |
| req_ready | output | NP | Per-port request ready |
| req_write | input | NP | Per-port store flag (1 = store, 0 = load) |
| req_addr | input | NP x ADDR_W | Per-port word address |
| req_wdata | input | NP x DATA_W | Per-port store data |
| rsp_valid | output | NP | Per-port done pulse |
| rsp_rdata | output | NP x DATA_W | Per-port load data, or store echo |

## Verification
The hardest situation to reach from the ports is an owner that is downgraded, or forced to write back its victim, in the same window in which other ports are competing for the bus. In that window a stale word would show up only as a wrong load value many cycles later.

Directed sequences first walk one address through every state change and time each response, so the hit and miss latencies reveal the hidden line states. A forced index conflict then evicts an owned line. After that, four ports issue random loads and stores over sixteen addresses that alias onto the eight indexes. A behavioural reference memory checks every response pulse on each clock.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_OWN = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_VWB  = 2'd1,
    BUS_SNP  = 2'd2,
    BUS_FIL  = 2'd3
  } bus_ph_e;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int N = 4,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic           advance,
  output logic [N-1:0]   gnt,
  output logic [IDW-1:0] gnt_id
);
  logic [IDW-1:0] ptr;
  logic           found;

  always_comb begin
    gnt    = '0;
    gnt_id = '0;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (int'(ptr) + k) % N;
      if (!found && req[c]) begin
        found  = 1'b1;
        gnt[c] = 1'b1;
        gnt_id = IDW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (advance && found) begin
      ptr <= (gnt_id == IDW'(N - 1)) ? '0 : gnt_id + 1'b1;
    end
  end

  // R10
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R9
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
endmodule

// File: rtl/coh_cache.sv
module coh_cache
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              vic_wb,
  output logic [ADDR_W-1:0] vic_addr,
  output logic [DATA_W-1:0] vic_data,
  input  logic              snp_en,
  input  logic              snp_inv,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_wb,
  output logic [DATA_W-1:0] snp_wbdata,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  line_st_e          st  [LINES];
  logic [TAG_W-1:0]  tg  [LINES];
  logic [DATA_W-1:0] dat [LINES];

  logic              busy;
  logic              l_write;
  logic [ADDR_W-1:0] l_addr;
  logic [DATA_W-1:0] l_wdata;

  logic [IDX_W-1:0]  r_idx, s_idx, l_idx;
  logic [TAG_W-1:0]  r_tag, s_tag, l_tag;
  logic              tag_hit, ld_hit, st_hit, accept, s_match;

  assign r_idx = req_addr[IDX_W-1:0];
  assign r_tag = req_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign l_idx = l_addr[IDX_W-1:0];
  assign l_tag = l_addr[ADDR_W-1:IDX_W];

  assign tag_hit = (st[r_idx] != LN_INV) && (tg[r_idx] == r_tag);
  assign ld_hit  = tag_hit && !req_write;
  assign st_hit  = tag_hit && req_write && (st[r_idx] == LN_OWN);

  assign req_ready = !busy && !snp_en;
  assign accept    = req_valid && req_ready;

  assign s_match    = snp_en && (st[s_idx] != LN_INV) && (tg[s_idx] == s_tag);
  assign snp_wb     = s_match && (st[s_idx] == LN_OWN);
  assign snp_wbdata = dat[s_idx];

  assign vic_wb   = busy && (st[l_idx] == LN_OWN) && (tg[l_idx] != l_tag);
  assign vic_addr = {tg[l_idx], l_idx};
  assign vic_data = dat[l_idx];

  assign bus_req   = busy;
  assign bus_write = l_write;
  assign bus_addr  = l_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= LN_INV;
    end else begin
      if (s_match) st[s_idx] <= snp_inv ? LN_INV : LN_SHR;
      if (fill_valid) st[l_idx] <= l_write ? LN_OWN : LN_SHR;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tg[l_idx]  <= l_tag;
      dat[l_idx] <= l_write ? l_wdata : fill_data;
    end
    if (accept && st_hit) dat[r_idx] <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      l_write   <= 1'b0;
      l_addr    <= '0;
      l_wdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (ld_hit || st_hit) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= req_write ? req_wdata : dat[r_idx];
        end else begin
          busy    <= 1'b1;
          l_write <= req_write;
          l_addr  <= req_addr;
          l_wdata <= req_wdata;
        end
      end
      if (fill_valid) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= l_write ? l_wdata : fill_data;
      end
    end
  end

  // R4
  fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> busy);

  // R2
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> rsp_valid);
endmodule

// File: rtl/coh_snoop_top.sv
module coh_snoop_top
  import coh_pkg::*;
#(
  parameter int NP     = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int WORDS = 1 << ADDR_W,
  localparam int IDW   = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NP-1:0]                req_valid,
  output logic [NP-1:0]                req_ready,
  input  logic [NP-1:0]                req_write,
  input  logic [NP-1:0][ADDR_W-1:0]    req_addr,
  input  logic [NP-1:0][DATA_W-1:0]    req_wdata,
  output logic [NP-1:0]                rsp_valid,
  output logic [NP-1:0][DATA_W-1:0]    rsp_rdata
);
  logic [NP-1:0]             bus_req, bus_write, vic_wb, snp_wb, snp_en, fill_valid;
  logic [NP-1:0][ADDR_W-1:0] bus_addr, vic_addr;
  logic [NP-1:0][DATA_W-1:0] vic_data, snp_wbdata;
  logic [NP-1:0]             arb_gnt;
  logic [IDW-1:0]            arb_id, gid;
  bus_ph_e                   ph;
  logic                      snp_inv;
  logic [ADDR_W-1:0]         snp_addr;
  logic [DATA_W-1:0]         fill_data, wb_sel;
  logic [DATA_W-1:0]         mem [WORDS];

  coh_rr_arb #(.N(NP)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (bus_req),
    .advance (ph == BUS_IDLE),
    .gnt     (arb_gnt),
    .gnt_id  (arb_id)
  );

  assign snp_inv   = bus_write[gid];
  assign snp_addr  = bus_addr[gid];
  assign fill_data = mem[bus_addr[gid]];

  for (genvar i = 0; i < NP; i++) begin : g_port
    assign snp_en[i]     = (ph == BUS_SNP) && (gid != IDW'(i));
    assign fill_valid[i] = (ph == BUS_FIL) && (gid == IDW'(i));

    coh_cache #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LINES  (LINES)
    ) u_cache (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid[i]),
      .req_ready  (req_ready[i]),
      .req_write  (req_write[i]),
      .req_addr   (req_addr[i]),
      .req_wdata  (req_wdata[i]),
      .rsp_valid  (rsp_valid[i]),
      .rsp_rdata  (rsp_rdata[i]),
      .bus_req    (bus_req[i]),
      .bus_write  (bus_write[i]),
      .bus_addr   (bus_addr[i]),
      .vic_wb     (vic_wb[i]),
      .vic_addr   (vic_addr[i]),
      .vic_data   (vic_data[i]),
      .snp_en     (snp_en[i]),
      .snp_inv    (snp_inv),
      .snp_addr   (snp_addr),
      .snp_wb     (snp_wb[i]),
      .snp_wbdata (snp_wbdata[i]),
      .fill_valid (fill_valid[i]),
      .fill_data  (fill_data)
    );
  end

  always_comb begin
    wb_sel = '0;
    for (int i = 0; i < NP; i++) begin
      if (snp_wb[i]) wb_sel = wb_sel | snp_wbdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= BUS_IDLE;
      gid <= '0;
    end else begin
      unique case (ph)
        BUS_IDLE: if (|arb_gnt) begin
          gid <= arb_id;
          ph  <= BUS_VWB;
        end
        BUS_VWB: ph <= BUS_SNP;
        BUS_SNP: ph <= BUS_FIL;
        BUS_FIL: ph <= BUS_IDLE;
        default: ph <= BUS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else begin
      if (ph == BUS_VWB && vic_wb[gid]) mem[vic_addr[gid]] <= vic_data[gid];
      if (ph == BUS_SNP && |snp_wb)     mem[bus_addr[gid]] <= wb_sel;
    end
  end

  // R10
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(snp_wb) <= 1);

  // R10
  fill_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid & ~bus_req) == '0);
endmodule

// File: tb/coh_snoop_top_bench.sv
module coh_snoop_top_bench;
  localparam int NP = 4;
  localparam int AW = 6;
  localparam int DW = 32;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NP-1:0]         req_valid = '0;
  logic [NP-1:0]         req_ready;
  logic [NP-1:0]         req_write = '0;
  logic [NP-1:0][AW-1:0] req_addr = '0;
  logic [NP-1:0][DW-1:0] req_wdata = '0;
  logic [NP-1:0]         rsp_valid;
  logic [NP-1:0][DW-1:0] rsp_rdata;

  coh_snoop_top #(.NP(NP), .ADDR_W(AW), .DATA_W(DW), .LINES(8)) u_coh_snoop_top (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [DW-1:0] model [64];
  bit            pend [NP];
  bit            pw   [NP];
  int            pa   [NP];
  logic [DW-1:0] pd   [NP];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference: a flat memory updated in response order.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        if (rsp_valid[p]) begin
          if (!pend[p]) begin
            check(0, "R2 response without request", 1, 0);
          end else begin
            if (!pw[p]) check(rsp_rdata[p] == model[pa[p]], "R7 load data", rsp_rdata[p], model[pa[p]]);
            else begin
              check(rsp_rdata[p] == pd[p], "R2 store echo", rsp_rdata[p], pd[p]);
              model[pa[p]] = pd[p];
            end
            pend[p] = 0;
          end
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    req_valid = '0;
    for (int i = 0; i < 64; i++) model[i] = '0;
    for (int p = 0; p < NP; p++) pend[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(input int p, input bit w, input int a, input logic [DW-1:0] d, output int lat);
    int acc;
    @(negedge clk);
    req_valid[p] = 1'b1;
    req_write[p] = w;
    req_addr[p]  = AW'(a);
    req_wdata[p] = d;
    while (!req_ready[p]) @(negedge clk);
    pw[p] = w; pa[p] = a; pd[p] = d; pend[p] = 1;
    acc = cyc + 1;
    @(negedge clk);
    req_valid[p] = 1'b0;
    while (!rsp_valid[p]) @(negedge clk);
    lat = cyc - acc;
  endtask

  task automatic rand_port(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      int lat;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      send(p, 1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), $urandom, lat);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    int rl [NP];
    do_reset();
    // R1 reset state
    repeat (2) begin
      @(negedge clk);
      check(req_ready == '1, "R1 ready after reset", req_ready, 4'hf);
      check(rsp_valid == '0, "R1 no response after reset", rsp_valid, 0);
    end

    send(0, 0, 5, 0, lat);           // R4 miss, R1 zero memory
    check(lat == 4, "R4 load miss latency", lat, 4);
    send(0, 0, 5, 0, lat);           // R3 shared load hit
    check(lat == 0, "R3 load hit latency", lat, 0);
    send(1, 1, 5, 32'hA1A1_0001, lat);
    check(lat == 4, "R6 store miss latency", lat, 4);
    send(0, 0, 5, 0, lat);           // R6 sharer was invalidated
    check(lat == 4, "R6 invalidated sharer misses", lat, 4);
    send(1, 0, 5, 0, lat);           // R5 owner kept Shared copy
    check(lat == 0, "R5 downgraded owner load hit", lat, 0);
    send(1, 1, 5, 32'hA2A2_0002, lat);
    check(lat == 4, "R5 store to downgraded line uses bus", lat, 4);
    send(1, 1, 5, 32'hA3A3_0003, lat);
    check(lat == 0, "R3 owned store hit", lat, 0);
    send(0, 0, 5, 0, lat);           // R6 plus R7 data
    check(lat == 4, "R6 other port misses after store", lat, 4);
    send(1, 1, 5, 32'hA4A4_0004, lat);
    send(1, 1, 13, 32'hB0B0_000D, lat); // R8 evicts owned line 5
    check(lat == 4, "R8 victim refill latency", lat, 4);
    send(2, 0, 5, 0, lat);           // R8 data checked by monitor
    check(lat == 4, "R8 evicted address load miss", lat, 4);
    send(3, 0, 13, 0, lat);          // R5 downgrade of new owner, R7

    // R9 simultaneous misses after reset
    @(negedge clk);
    do_reset();
    fork
      send(0, 0, 16, 0, rl[0]);
      send(1, 1, 17, 32'h1111, rl[1]);
      send(2, 0, 18, 0, rl[2]);
      send(3, 1, 19, 32'h3333, rl[3]);
    join
    for (int p = 0; p < NP; p++)
      check(rl[p] == 4 * (p + 1), "R9 round-robin completion order", rl[p], 4 * (p + 1));

    // R7 random mixed traffic over aliasing addresses
    fork
      rand_port(0, 150);
      rand_port(1, 150);
      rand_port(2, 150);
      rand_port(3, 150);
    join
    repeat (4) @(negedge clk);
    for (int p = 0; p < NP; p++)
      check(pend[p] == 0, "R2 every request answered", pend[p], 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule